// File: doc/BRIEF.md
# Dual-Port RAM with Same-Address Arbitration

This block is a synchronous memory with two fully independent ports, called A (left) and B (right). Each port has its own enable, write select, output enable, address and write data. Either port can read or write any word in any cycle. Both ports can use the memory in the same cycle, including at the same address.

When both enabled ports present the same address, a comparator and a small arbiter choose a winner:

- A port that was already enabled in the previous cycle beats a port that has just been enabled.
- If both ports became enabled in the same cycle, port A wins.

The losing port sees its busy flag go high in that same cycle, and any write it issues is dropped. Reads from a losing port still complete.

A mode strap supports wider memories built from several copies of this block. In master mode, the local arbiter drives the busy outputs. In slave mode, the local decision is discarded, the busy outputs stay low, and each port takes its busy state from an input driven by the master copy. One arbitration decision then governs every byte lane.

Top module: `twin_port_ram`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both read-data outputs and both busy outputs are zero.
- R2: A read issued in cycle N returns the stored word on that port's read-data output after the clock edge that ends cycle N (one cycle of latency).
- R3: Both ports can read or write different addresses in the same cycle without interfering, including the last address DEPTH-1.
- R4: In master mode, if both ports are enabled on the same address and both became enabled in the same cycle, only B's busy output goes high.
- R5: In master mode, a port enabled in the previous cycle wins the same-address contest against a port newly enabled in this cycle, and only the newcomer's busy output goes high.
- R6: A write from a port whose effective busy state is high leaves memory unchanged.
- R7: A port with its enable low takes part in neither access nor arbitration: its write is dropped and the other port's busy stays low.
- R8: A port's read-data output carries data only if that port had enable high, write select low (read) and output enable high in the issuing cycle. Otherwise the output is all zeros.
- R9: When one port reads and the other port writes the same address in the same cycle, the read returns the word that was stored before the write.
- R10: In slave mode (mode strap low), both busy outputs stay low, and a high busy input blocks that port's writes.
- R11: In master mode, the busy inputs have no effect on writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | 1 = local arbitration drives busy; 0 = busy taken from inputs |
| a_en | input | 1 | Port A enable |
| a_wr | input | 1 | Port A: 1 = write, 0 = read |
| a_oe | input | 1 | Port A output enable |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data, zero when gated |
| a_busy_in | input | 1 | Port A busy from master copy (slave mode) |
| a_busy_out | output | 1 | Port A busy from local arbiter (master mode) |
| b_en | input | 1 | Port B enable |
| b_wr | input | 1 | Port B: 1 = write, 0 = read |
| b_oe | input | 1 | Port B output enable |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data, zero when gated |
| b_busy_in | input | 1 | Port B busy from master copy (slave mode) |
| b_busy_out | output | 1 | Port B busy from local arbiter (master mode) |

## Verification
The bench builds the block with DATA_W=9 and DEPTH=4096.

- The nine-bit width puts patterns that use the top data bit within reach, so a datapath truncated to eight bits would be caught.
- The 4096-word depth makes address 4095 reachable, which exercises the full twelve-bit address compare.

With these values the bench drives tie, hold-wins, idle-port and cross-port read-during-write contests. Each contest is checked through the busy flags in the same cycle and through later read-back of the contested word.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
    localparam int NPORT = 2;
    localparam int PA    = 0;
    localparam int PB    = 1;

    typedef struct packed {
        logic a_held;
        logic b_held;
    } arb_state_t;
endpackage

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en,
    input  logic              b_en,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [ADDR_W-1:0] b_addr,
    output logic              a_lose,
    output logic              b_lose
);
    arb_state_t st_d, st_q;
    logic       clash;

    always_comb begin
        st_d        = st_q;
        st_d.a_held = a_en;
        st_d.b_held = b_en;
        clash       = a_en && b_en && (a_addr == b_addr);
        a_lose      = 1'b0;
        b_lose      = 1'b0;
        if (clash) begin
            if (st_q.b_held && !st_q.a_held) a_lose = 1'b1;
            else                             b_lose = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_one_loser_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_lose && b_lose));

    p_holder_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && b_en && a_addr == b_addr && $past(b_en) && !$past(a_en)) |-> (a_lose && !b_lose));

    p_idle_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_en || !b_en) |-> (!a_lose && !b_lose));
endmodule

// File: rtl/dpr_store.sv
module dpr_store
    import dpram_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 4096,
    parameter int ADDR_W = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NPORT-1:0]              en,
    input  logic [NPORT-1:0]              wr,
    input  logic [NPORT-1:0]              oe,
    input  logic [NPORT-1:0]              blk,
    input  logic [NPORT-1:0][ADDR_W-1:0]  addr,
    input  logic [NPORT-1:0][DATA_W-1:0]  wdata,
    output logic [NPORT-1:0][DATA_W-1:0]  rdata
);
    logic [DATA_W-1:0]             mem [DEPTH];
    logic [NPORT-1:0]              we;
    logic [NPORT-1:0]              show_d, show_q;
    logic [NPORT-1:0][DATA_W-1:0]  data_d, data_q;

    always_comb begin
        show_d = show_q;
        data_d = data_q;
        for (int p = 0; p < NPORT; p++) begin
            we[p]     = en[p] && wr[p] && !blk[p];
            show_d[p] = en[p] && oe[p] && !wr[p];
            data_d[p] = mem[addr[p]];
            rdata[p]  = show_q[p] ? data_q[p] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            show_q <= '0;
            data_q <= '0;
        end else begin
            show_q <= show_d;
            data_q <= data_d;
        end
    end

    // Port B first so that port A lands last if both write one word.
    always_ff @(posedge clk) begin
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (we[p]) mem[addr[p]] <= wdata[p];
        end
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_chk
        localparam int OTHER = NPORT - 1 - g;

        p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (en[g] && wr[g] && blk[g] &&
             !(en[OTHER] && wr[OTHER] && !blk[OTHER] && addr[OTHER] == addr[g]))
            |=> (mem[$past(addr[g])] == $past(mem[addr[g]])));

        p_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(en[g] && oe[g] && !wr[g]) |-> (rdata[g] == '0));
    end
endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram
    import dpram_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 4096,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              a_en,
    input  logic              a_wr,
    input  logic              a_oe,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              a_busy_in,
    output logic              a_busy_out,
    input  logic              b_en,
    input  logic              b_wr,
    input  logic              b_oe,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    input  logic              b_busy_in,
    output logic              b_busy_out
);
    logic                          a_lose, b_lose;
    logic [NPORT-1:0]              blk;
    logic [NPORT-1:0][ADDR_W-1:0]  addr_v;
    logic [NPORT-1:0][DATA_W-1:0]  wdata_v, rdata_v;

    dpr_arbiter #(.ADDR_W(ADDR_W)) i_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_en   (a_en),
        .b_en   (b_en),
        .a_addr (a_addr),
        .b_addr (b_addr),
        .a_lose (a_lose),
        .b_lose (b_lose)
    );

    always_comb begin
        blk[PA]     = master_mode ? a_lose : a_busy_in;
        blk[PB]     = master_mode ? b_lose : b_busy_in;
        a_busy_out  = master_mode && a_lose;
        b_busy_out  = master_mode && b_lose;
        addr_v[PA]  = a_addr;
        addr_v[PB]  = b_addr;
        wdata_v[PA] = a_wdata;
        wdata_v[PB] = b_wdata;
        a_rdata     = rdata_v[PA];
        b_rdata     = rdata_v[PB];
    end

    dpr_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .en    ({b_en, a_en}),
        .wr    ({b_wr, a_wr}),
        .oe    ({b_oe, a_oe}),
        .blk   (blk),
        .addr  (addr_v),
        .wdata (wdata_v),
        .rdata (rdata_v)
    );
endmodule

// File: tb/test_twin_port_ram.sv
module test_twin_port_ram;
    localparam int DW = 9;
    localparam int DP = 4096;
    localparam int AW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_mode = 1'b1;
    logic a_en = 0, a_wr = 0, a_oe = 0, a_busy_in = 0;
    logic b_en = 0, b_wr = 0, b_oe = 0, b_busy_in = 0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;
    logic [DW-1:0] a_rdata, b_rdata;
    logic a_busy_out, b_busy_out;

    always #4 clk = ~clk;   // 125 MHz

    twin_port_ram #(.DATA_W(DW), .DEPTH(DP)) i_twin_port_ram (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .a_en(a_en), .a_wr(a_wr), .a_oe(a_oe), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_busy_in(a_busy_in), .a_busy_out(a_busy_out),
        .b_en(b_en), .b_wr(b_wr), .b_oe(b_oe), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_busy_in(b_busy_in), .b_busy_out(b_busy_out)
    );

    typedef struct {
        logic [DW-1:0] ea;
        logic [DW-1:0] eb;
        string         tag;
    } exp_t;

    exp_t          sb_q[$];
    logic [DW-1:0] model [DP];
    logic          prev_a = 0, prev_b = 0;
    int            total = 0, bad = 0;
    bit            finished = 0;

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: called at a falling edge; drives one cycle and queues the result.
    task automatic cyc(input logic aen, awr, aoe, input logic [AW-1:0] aad, input logic [DW-1:0] awd,
                       input logic ben, bwr, boe, input logic [AW-1:0] bad_, input logic [DW-1:0] bwd,
                       input string tag);
        logic la, lb, ba, bb;
        exp_t it;
        a_en = aen; a_wr = awr; a_oe = aoe; a_addr = aad; a_wdata = awd;
        b_en = ben; b_wr = bwr; b_oe = boe; b_addr = bad_; b_wdata = bwd;
        la = 0; lb = 0;
        if (aen && ben && aad == bad_) begin
            if (prev_b && !prev_a) la = 1; else lb = 1;
        end
        ba = master_mode ? la : a_busy_in;
        bb = master_mode ? lb : b_busy_in;
        #1;
        chk({tag, " busyA"}, a_busy_out, master_mode && la);
        chk({tag, " busyB"}, b_busy_out, master_mode && lb);
        it.ea  = (aen && aoe && !awr) ? model[aad] : '0;
        it.eb  = (ben && boe && !bwr) ? model[bad_] : '0;
        it.tag = tag;
        sb_q.push_back(it);
        if (ben && bwr && !bb) model[bad_] = bwd;
        if (aen && awr && !ba) model[aad] = awd;
        prev_a = aen; prev_b = ben;
        @(negedge clk);
    endtask

    task automatic idle(string tag);
        cyc(0, 0, 0, '0, '0, 0, 0, 0, '0, '0, tag);
    endtask

    // Monitor: pops one expected item per clock, after outputs settle.
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            chk({it.tag, " rdataA"}, a_rdata, it.ea);
            chk({it.tag, " rdataB"}, b_rdata, it.eb);
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DP; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset rdataA", a_rdata, '0);
        chk("R1 reset rdataB", b_rdata, '0);
        chk("R1 reset busyA", {8'd0, a_busy_out}, '0);
        chk("R1 reset busyB", {8'd0, b_busy_out}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset rdataA", a_rdata, '0);

        // R3 / R2: independent writes, then reads, including top address
        cyc(1, 1, 0, 12'd5, 9'h1A5, 1, 1, 0, 12'd4095, 9'h155, "R3 wr");
        cyc(1, 0, 1, 12'd5, '0, 1, 0, 1, 12'd4095, '0, "R2 R3 rd");
        cyc(1, 0, 1, 12'd4095, '0, 1, 0, 1, 12'd5, '0, "R3 cross rd");
        // R8: gating
        cyc(1, 0, 0, 12'd5, '0, 0, 0, 1, 12'd5, '0, "R8 oe low / en low");
        cyc(1, 1, 1, 12'd7, 9'h0F0, 1, 0, 1, 12'd5, '0, "R8 write with oe");
        idle("R4 gap");
        // R4: tie -> A wins, B write dropped (R6)
        cyc(1, 1, 0, 12'd10, 9'h0AA, 1, 1, 0, 12'd10, 9'h111, "R4 tie");
        idle("R4 gap2");
        cyc(1, 0, 1, 12'd10, '0, 0, 0, 0, '0, '0, "R6 R4 readback");
        // R5: B held, A newly enabled -> A busy, A write dropped
        cyc(0, 0, 0, '0, '0, 1, 1, 0, 12'd20, 9'h033, "R5 preload");
        cyc(1, 1, 0, 12'd20, 9'h077, 1, 0, 1, 12'd20, '0, "R5 holder wins");
        idle("R5 gap");
        cyc(1, 0, 1, 12'd20, '0, 0, 0, 0, '0, '0, "R6 R5 readback");
        // R9: B held writes, A newly reads same word -> old data
        cyc(0, 0, 0, '0, '0, 1, 1, 0, 12'd30, 9'h0F0, "R9 preload");
        cyc(1, 0, 1, 12'd30, '0, 1, 1, 0, 12'd30, 9'h10F, "R9 rd old");
        cyc(1, 0, 1, 12'd30, '0, 0, 0, 0, '0, '0, "R9 rd new");
        // R7: idle port neither writes nor contests
        cyc(1, 0, 1, 12'd40, '0, 0, 1, 0, 12'd40, 9'h1FF, "R7 idle port");
        cyc(1, 0, 1, 12'd40, '0, 0, 0, 0, '0, '0, "R7 readback");
        // R10: slave mode
        master_mode = 1'b0; a_busy_in = 1'b1; b_busy_in = 1'b0;
        idle("R10 gap");
        cyc(1, 1, 0, 12'd50, 9'h0C3, 1, 1, 0, 12'd50, 9'h13C, "R10 slave both wr");
        cyc(1, 1, 0, 12'd51, 9'h0C3, 0, 0, 0, '0, '0, "R10 busy_in blocks");
        cyc(1, 0, 1, 12'd50, '0, 1, 0, 1, 12'd51, '0, "R10 readback");
        // R11: master ignores busy_in
        master_mode = 1'b1; a_busy_in = 1'b1; b_busy_in = 1'b1;
        idle("R11 gap");
        cyc(1, 1, 0, 12'd60, 9'h1C7, 0, 0, 0, '0, '0, "R11 wr");
        cyc(1, 0, 1, 12'd60, '0, 0, 0, 0, '0, '0, "R11 readback");
        idle("end");
        idle("end2");
        finish_run();
    end
endmodule